// File: doc/BRIEF.md
# Context-Tagged TLB with Low-Window Address Remap

This block is a small, fully associative translation buffer. It turns each incoming 32-bit virtual address into a remapped address before it compares any tag. A 7-bit process number register drives the remap. Any virtual address whose top seven bits are all zero falls in the low 32 MB window. For such an address the block replaces those seven bits with the current process number. Up to 128 processes can therefore share the low window without flushing the buffer on a context switch. An 8-bit address-space register also tags every entry that is not marked global. Such an entry is visible only while that register holds the entry's stored value, which gives 256 address spaces.

Software loads the process number and the address-space value through two write strobes. Translations enter through a fill port that carries the virtual page, the physical page and a global flag. Lookups are registered and answer one cycle after they are requested. Two maintenance commands are provided. The by-address invalidate removes only entries that are visible in the current context. The invalidate-all command clears the whole buffer in one cycle. Page table walking, permission checks and caches belong to other blocks.

Top module: `ctx_tlb`

## Requirements
- R1: When bits 31:25 of an address are all zero, its remapped form is the 7-bit process number in bits 31:25 with bits 24:0 unchanged. Lookups, fills and by-address invalidates all use this remapped form, and tags compare remapped bits 31:12 (4 KB pages).
- R2: When any of bits 31:25 is nonzero, the remapped address equals the input address. A process number of zero leaves every address unchanged.
- R3: When lk_valid is high in a cycle, exactly one of lk_hit and lk_miss is high in the next cycle. lk_ppn carries the stored physical page on a hit and zero on a miss. With no request, both lk_hit and lk_miss are low in the following cycle.
- R4: An entry with its global flag clear hits only while the address-space register equals the value that was current when the entry was filled. A global entry hits under any address-space value.
- R5: A fill is visible to lookups that start in the cycle after it. A lookup in the same cycle as the fill sees the earlier contents.
- R6: A fill whose remapped page matches an entry that is visible in the current context overwrites that entry in place.
- R7: A fill that matches no visible entry goes to the lowest-numbered invalid entry. When all 8 entries are valid, it replaces the entry named by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one on each such replacement.
- R8: A by-address invalidate forms the remapped address with the current process number. It removes a matching entry only if that entry is global or carries the current address-space value. Matching entries of other address spaces stay.
- R9: Invalidate-all clears every entry in one cycle and takes priority over a fill in the same cycle.
- R10: A write to the process-number or address-space register affects lookups from the next cycle on. A lookup in the same cycle uses the old value, and the write flushes no entry.
- R11: After reset, the process number and address-space value are zero, no entry is valid, and lk_hit and lk_miss are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pid_we | input | 1 | Write strobe for the process number |
| pid_wdata | input | 7 | New process number |
| asid_we | input | 1 | Write strobe for the address-space value |
| asid_wdata | input | 8 | New address-space value |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit, one cycle after request |
| lk_miss | output | 1 | Lookup miss, one cycle after request |
| lk_ppn | output | 20 | Physical page number on hit, else zero |
| fill_valid | input | 1 | Fill strobe |
| fill_va | input | 32 | Virtual address of page to fill |
| fill_ppn | input | 20 | Physical page number to store |
| fill_global | input | 1 | Store entry as global |
| inv_addr_valid | input | 1 | Invalidate-by-address strobe |
| inv_addr_va | input | 32 | Address to invalidate |
| inv_all | input | 1 | Invalidate every entry |

## Verification
Corrupt internal state in this block shows up at the ports as a wrong hit, miss or physical page on the first lookup of the affected page. That lookup answers one cycle after it is requested. A stale process number or address-space value shows up the same way, on a low-window page or a non-global page. A round-robin pointer that has drifted shows up only when the buffer is full: the next replacement evicts the wrong page, and a lookup of the survivor or of the victim reveals it. The bench therefore fills the buffer to capacity and probes pages on both sides of each eviction.

// File: rtl/ctx_tlb.sv
module ctx_tlb #(
  parameter int ENTRIES    = 8,
  parameter int PID_W      = 7,
  parameter int ASID_W     = 8,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pid_we,
  input  logic [PID_W-1:0]  pid_wdata,
  input  logic              asid_we,
  input  logic [ASID_W-1:0] asid_wdata,
  input  logic              lk_valid,
  input  logic [31:0]       lk_va,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [31-PAGE_SHIFT:0] lk_ppn,
  input  logic              fill_valid,
  input  logic [31:0]       fill_va,
  input  logic [31-PAGE_SHIFT:0] fill_ppn,
  input  logic              fill_global,
  input  logic              inv_addr_valid,
  input  logic [31:0]       inv_addr_va,
  input  logic              inv_all
);
  localparam int VA_W    = 32;
  localparam int TAG_W   = VA_W - PAGE_SHIFT;
  localparam int WIN_LSB = VA_W - PID_W;
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [VA_W-1:0] remap(input logic [VA_W-1:0] va,
                                            input logic [PID_W-1:0] pid);
    return (va[VA_W-1:WIN_LSB] == '0) ? {pid, va[WIN_LSB-1:0]} : va;
  endfunction

  function automatic logic [IDX_W-1:0] low_idx(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [PID_W-1:0]  pid_q;
  logic [ASID_W-1:0] asid_q;
  logic [IDX_W-1:0]  rr_q;
  logic [ENTRIES-1:0] vld_q, glb_q, vld_d;
  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [TAG_W-1:0]  ppn_q  [ENTRIES];
  logic [ASID_W-1:0] easid_q[ENTRIES];

  logic [VA_W-1:0] lk_mva, fl_mva, iv_mva;
  assign lk_mva = remap(lk_va, pid_q);
  assign fl_mva = remap(fill_va, pid_q);
  assign iv_mva = remap(inv_addr_va, pid_q);

  logic [ENTRIES-1:0] visible, lk_match, fl_match, iv_match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign visible[g]  = vld_q[g] && (glb_q[g] || easid_q[g] == asid_q);
    assign lk_match[g] = visible[g] && tag_q[g] == lk_mva[VA_W-1:PAGE_SHIFT];
    assign fl_match[g] = visible[g] && tag_q[g] == fl_mva[VA_W-1:PAGE_SHIFT];
    assign iv_match[g] = visible[g] && tag_q[g] == iv_mva[VA_W-1:PAGE_SHIFT];
  end

  logic             lk_any, fl_any, full;
  logic [IDX_W-1:0] lk_idx, fl_idx;
  assign lk_any = |lk_match;
  assign fl_any = |fl_match;
  assign full   = &vld_q;
  assign lk_idx = low_idx(lk_match);
  assign fl_idx = fl_any ? low_idx(fl_match) : (!full ? low_idx(~vld_q) : rr_q);

  always_comb begin
    vld_d = vld_q;
    if (inv_addr_valid) vld_d = vld_d & ~iv_match;
    if (fill_valid)     vld_d[fl_idx] = 1'b1;
    if (inv_all)        vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pid_q  <= '0;
      asid_q <= '0;
      rr_q   <= '0;
      vld_q  <= '0;
      glb_q  <= '0;
    end else begin
      if (pid_we)  pid_q  <= pid_wdata;
      if (asid_we) asid_q <= asid_wdata;
      vld_q <= vld_d;
      if (fill_valid && !inv_all) begin
        glb_q[fl_idx] <= fill_global;
        if (!fl_any && full)
          rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_valid && fl_idx == IDX_W'(i)) begin
        tag_q[i]   <= fl_mva[VA_W-1:PAGE_SHIFT];
        ppn_q[i]   <= fill_ppn;
        easid_q[i] <= asid_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_hit  <= 1'b0;
      lk_miss <= 1'b0;
      lk_ppn  <= '0;
    end else begin
      lk_hit  <= lk_valid && lk_any;
      lk_miss <= lk_valid && !lk_any;
      lk_ppn  <= (lk_valid && lk_any) ? ppn_q[lk_idx] : '0;
    end
  end
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
  parameter int ENTRIES = 8,
  parameter int PID_W   = 7,
  parameter int PPN_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic [PPN_W-1:0]   lk_ppn,
  input logic               pid_we,
  input logic [PID_W-1:0]   pid_wdata,
  input logic               asid_we,
  input logic               fill_valid,
  input logic               inv_addr_valid,
  input logic               inv_all,
  input logic [PID_W-1:0]   pid,
  input logic [ENTRIES-1:0] vld
);
  p_one_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (lk_hit != lk_miss));
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!lk_hit && !lk_miss));
  p_miss_page_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> lk_ppn == '0);
  p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !inv_all) |=> vld != '0);
  p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> vld == '0);
  p_pid_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pid_we |=> pid == $past(pid_wdata));
  p_no_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pid_we || asid_we) && !fill_valid && !inv_addr_valid && !inv_all)
      |=> vld == $past(vld));
endmodule

bind ctx_tlb ctx_tlb_chk #(.ENTRIES(ENTRIES), .PID_W(PID_W), .PPN_W(32 - PAGE_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_miss(lk_miss),
  .lk_ppn(lk_ppn), .pid_we(pid_we), .pid_wdata(pid_wdata), .asid_we(asid_we),
  .fill_valid(fill_valid), .inv_addr_valid(inv_addr_valid), .inv_all(inv_all),
  .pid(pid_q), .vld(vld_q)
);

// File: tb/tb_ctx_tlb.sv
module tb_ctx_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pid_we = 0, asid_we = 0, lk_valid = 0, fill_valid = 0, fill_global = 0;
  logic        inv_addr_valid = 0, inv_all = 0;
  logic [6:0]  pid_wdata = '0;
  logic [7:0]  asid_wdata = '0;
  logic [31:0] lk_va = '0, fill_va = '0, inv_addr_va = '0;
  logic [19:0] fill_ppn = '0;
  logic        lk_hit, lk_miss;
  logic [19:0] lk_ppn;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctx_tlb dut (
    .clk(clk), .rst_n(rst_n), .pid_we(pid_we), .pid_wdata(pid_wdata),
    .asid_we(asid_we), .asid_wdata(asid_wdata), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_ppn(lk_ppn), .fill_valid(fill_valid),
    .fill_va(fill_va), .fill_ppn(fill_ppn), .fill_global(fill_global),
    .inv_addr_valid(inv_addr_valid), .inv_addr_va(inv_addr_va), .inv_all(inv_all)
  );

  // row: op(3) va(32) data(20) global(1) exp_hit(1) exp_ppn(20) req(4)
  // op: 0 lookup, 1 fill, 2 write pid, 3 write asid, 4 invalidate by address
  localparam int N = 27;
  localparam logic [80:0] TBL [N] = '{
    {3'd3, 32'h0,        20'd5,     1'b0, 1'b0, 20'h0,     4'd10},
    {3'd1, 32'h00001000, 20'h11111, 1'b0, 1'b0, 20'h0,     4'd5},
    {3'd0, 32'h00001000, 20'h0,     1'b0, 1'b1, 20'h11111, 4'd4},  // R4
    {3'd2, 32'h0,        20'd3,     1'b0, 1'b0, 20'h0,     4'd10},
    {3'd0, 32'h00001000, 20'h0,     1'b0, 1'b0, 20'h0,     4'd1},  // R1 remapped miss
    {3'd1, 32'h00001000, 20'h22222, 1'b0, 1'b0, 20'h0,     4'd1},
    {3'd0, 32'h00001000, 20'h0,     1'b0, 1'b1, 20'h22222, 4'd1},  // R1
    {3'd0, 32'h06001000, 20'h0,     1'b0, 1'b1, 20'h22222, 4'd2},  // R2 high bits pass
    {3'd2, 32'h0,        20'd0,     1'b0, 1'b0, 20'h0,     4'd10},
    {3'd0, 32'h00001000, 20'h0,     1'b0, 1'b1, 20'h11111, 4'd2},  // R2 pid zero
    {3'd3, 32'h0,        20'd9,     1'b0, 1'b0, 20'h0,     4'd10},
    {3'd0, 32'h00001000, 20'h0,     1'b0, 1'b0, 20'h0,     4'd4},  // R4 other asid
    {3'd1, 32'h80000000, 20'h33333, 1'b1, 1'b0, 20'h0,     4'd4},
    {3'd3, 32'h0,        20'd5,     1'b0, 1'b0, 20'h0,     4'd10},
    {3'd0, 32'h80000000, 20'h0,     1'b0, 1'b1, 20'h33333, 4'd4},  // R4 global
    {3'd1, 32'h00001000, 20'h44444, 1'b0, 1'b0, 20'h0,     4'd6},
    {3'd0, 32'h00001000, 20'h0,     1'b0, 1'b1, 20'h44444, 4'd6},  // R6 overwrite
    {3'd3, 32'h0,        20'd9,     1'b0, 1'b0, 20'h0,     4'd10},
    {3'd1, 32'h00001000, 20'h55555, 1'b0, 1'b0, 20'h0,     4'd4},
    {3'd0, 32'h00001000, 20'h0,     1'b0, 1'b1, 20'h55555, 4'd4},
    {3'd4, 32'h00001000, 20'h0,     1'b0, 1'b0, 20'h0,     4'd8},
    {3'd0, 32'h00001000, 20'h0,     1'b0, 1'b0, 20'h0,     4'd8},  // R8 removed
    {3'd3, 32'h0,        20'd5,     1'b0, 1'b0, 20'h0,     4'd10},
    {3'd0, 32'h00001000, 20'h0,     1'b0, 1'b1, 20'h44444, 4'd8},  // R8 other asid kept
    {3'd4, 32'h80000000, 20'h0,     1'b0, 1'b0, 20'h0,     4'd8},
    {3'd3, 32'h0,        20'd9,     1'b0, 1'b0, 20'h0,     4'd10},
    {3'd0, 32'h80000000, 20'h0,     1'b0, 1'b0, 20'h0,     4'd8}   // R8 global removed
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    pid_we = 0; asid_we = 0; lk_valid = 0; fill_valid = 0;
    inv_addr_valid = 0; inv_all = 0;
  endtask

  task automatic expect_lk(input bit eh, input logic [19:0] ep, input string tag);
    logic [19:0] want;
    want = eh ? ep : 20'h0;
    checks++;
    if (lk_hit !== eh || lk_miss !== !eh || lk_ppn !== want) begin
      fails++;
      $display("FAIL %s: hit=%0b miss=%0b ppn=%h expected hit=%0b miss=%0b ppn=%h",
               tag, lk_hit, lk_miss, lk_ppn, eh, !eh, want);
    end
  endtask

  task automatic look(input logic [31:0] va, input bit eh, input logic [19:0] ep,
                      input string tag);
    lk_valid = 1; lk_va = va;
    step();
    expect_lk(eh, ep, tag);
  endtask

  task automatic fill(input logic [31:0] va, input logic [19:0] p, input bit g);
    fill_valid = 1; fill_va = va; fill_ppn = p; fill_global = g;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    foreach (TBL[k]) begin
      logic [80:0] r;
      r = TBL[k];
      case (r[80:78])
        3'd0: look(r[77:46], r[24], r[23:4], $sformatf("R%0d row %0d", r[3:0], k));
        3'd1: fill(r[77:46], r[45:26], r[25]);
        3'd2: begin pid_we = 1; pid_wdata = r[32:26]; step(); end
        3'd3: begin asid_we = 1; asid_wdata = r[33:26]; step(); end
        default: begin inv_addr_valid = 1; inv_addr_va = r[77:46]; step(); end
      endcase
    end

    // R11 reset state
    rst_n = 0;
    repeat (2) @(negedge clk);
    checks++;
    if (lk_hit !== 0 || lk_miss !== 0) begin
      fails++;
      $display("FAIL R11: hit=%0b miss=%0b expected 0 0", lk_hit, lk_miss);
    end
    rst_n = 1;
    @(negedge clk);
    look(32'h80000000, 0, 0, "R11 empty after reset");

    // R3 no request gives no answer
    step();
    checks++;
    if (lk_hit !== 0 || lk_miss !== 0) begin
      fails++;
      $display("FAIL R3 idle: hit=%0b miss=%0b expected 0 0", lk_hit, lk_miss);
    end

    // R7 fill to capacity, then round-robin eviction
    for (int i = 0; i < 8; i++) fill(32'h10000 + i * 32'h1000, 20'h100 + 20'(i), 1'b1);
    for (int i = 0; i < 8; i++)
      look(32'h10000 + i * 32'h1000, 1, 20'h100 + 20'(i), "R7 all resident");
    fill(32'h20000, 20'h200, 1'b1);
    look(32'h10000, 0, 0,      "R7 first victim is entry 0");
    look(32'h11000, 1, 20'h101, "R7 entry 1 survives");
    look(32'h20000, 1, 20'h200, "R7 new page present");
    fill(32'h21000, 20'h201, 1'b1);
    look(32'h11000, 0, 0,      "R7 second victim is entry 1");
    look(32'h12000, 1, 20'h102, "R7 entry 2 survives");

    // R9 invalidate-all beats a same-cycle fill
    inv_all = 1; fill_valid = 1; fill_va = 32'h30000; fill_ppn = 20'h300; fill_global = 1;
    step();
    look(32'h30000, 0, 0, "R9 fill dropped by flush");
    look(32'h12000, 0, 0, "R9 old page gone");

    // R5 same-cycle fill and lookup
    fill_valid = 1; fill_va = 32'h40000; fill_ppn = 20'h400; fill_global = 1;
    lk_valid = 1; lk_va = 32'h40000;
    step();
    expect_lk(0, 0, "R5 same-cycle lookup sees old contents");
    look(32'h40000, 1, 20'h400, "R5 next-cycle lookup sees fill");

    // R10 register write timing and no flush
    fill(32'h2000, 20'h0AAAA, 1'b1);
    pid_we = 1; pid_wdata = 7'd1; lk_valid = 1; lk_va = 32'h2000;
    step();
    expect_lk(1, 20'h0AAAA, "R10 same-cycle lookup uses old pid");
    look(32'h2000, 0, 0, "R10 new pid remaps");
    pid_we = 1; pid_wdata = 7'd0;
    step();
    look(32'h2000, 1, 20'h0AAAA, "R10 entry kept across pid change");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule